// File: doc/BRIEF.md
# Soft-Start and Overcurrent Sequencer

This block is the digital start-up and fault controller of a voltage-mode buck regulator. A one-clock strobe marks the start of every switching cycle. On each strobe the block decides whether the power switch may turn on in that cycle. While a start-up is in progress it drives a reference code that climbs in equal stairs, and the error amplifier's reference input follows that code. The block also opens a short blanking window at the start of each on-time. A current-limit comparator flag is read once, on the last clock of that window.

Overcurrent is handled in one of two ways, depending on the phase. During the start-up ramp the block holds a roughly constant current by skipping cycles. Each repeated fault raises the number of skipped cycles by one, up to a ceiling, and each clean cycle lowers it by one. Once the output is in regulation, a single fault switches the pulse off, clears the reference and holds an off-period of a fixed number of switching cycles. After that a fresh ramp begins. Under a sustained short the block therefore alternates between the off-period and current-limited ramping at as little as one eighth of the normal pulse rate. Removing the enable puts the block at rest at once.

Top module: `ssoc_seq`

## Requirements
- R1: In the ramp state the reference code starts at 0 and rises by exactly one on every STEP_CYC-th strobe (default 32) until it equals STEPS (default 64). After strobe k of a ramp it reads floor(k/STEP_CYC). It never changes by more than one per step and never exceeds STEPS.
- R2: The clock after the code reaches STEPS, the block enters regulation (st_regulate high, st_softstart low). The code then holds at STEPS for as long as it stays in regulation.
- R3: On a strobe that is allowed to fire, pulse_allow and blank_win go high on the next clock. blank_win stays high for BLANK_CLK clocks. oc_flag is sampled only on the clock edge that ends the window, and only if pulse_allow is still high. Values of oc_flag at any other time have no effect.
- R4: In the ramp state, a sampled overcurrent drops pulse_allow on the same edge. It also sets the skip level to one more than its old value, saturating at MAX_SKIP (default 7). The next that many strobes then leave pulse_allow low. Skipped cycles do not sample the flag.
- R5: In the ramp state, a fired cycle whose sample shows no overcurrent lowers the skip level by one, but not below zero.
- R6: In regulation, a sampled overcurrent drops pulse_allow and clears the reference code to 0 on the same edge, and enters the off-period (st_hiccup high). The block allows no pulse for HICCUP_CYC strobes (default 2048). The last of those strobes starts a new ramp from code 0 with no skips pending.
- R7: Skipped cycles still pending when the ramp ends are carried out in regulation before the next pulse is allowed.
- R8: While en is low the block is idle: ref_code is 0, pulse_allow and blank_win are low, all state flags are low and no skips are pending. One clock after en rises, the ramp state is entered with code 0.
- R9: After a synchronous reset, ref_code is 0 and pulse_allow, blank_win and all state flags are low.
- R10: At most one of st_softstart, st_regulate and st_hiccup is high at any time. All three are low when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces the idle state |
| cyc_strobe | input | 1 | One-clock pulse at the start of each switching cycle |
| oc_flag | input | 1 | Current-limit comparator output |
| ref_code | output | $clog2(STEPS+1) | Staircase reference code for the error amplifier |
| pulse_allow | output | 1 | Switch may conduct in the current cycle |
| blank_win | output | 1 | Current-sense blanking window is open |
| st_softstart | output | 1 | Ramp state |
| st_regulate | output | 1 | Regulation state |
| st_hiccup | output | 1 | Overcurrent off-period |

## Verification
The assertions assume that strobes are at least BLANK_CLK+1 clocks apart. This keeps a new cycle from ever starting while a blanking window is still open. They also assume BLANK_CLK is at least two, so the sampling edge occurs once per window. The stimulus uses a fixed cycle of eight clocks with a three-clock window. It holds oc_flag steady across a cycle, except in one case where it drops the flag back to low before the window closes. In that case the asserted flag falls only inside the ignored part of the window.

// File: rtl/ssoc_pkg.sv
package ssoc_pkg;

    // Sequencer phase
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RAMP = 2'd1,
        SEQ_REG  = 2'd2,
        SEQ_HIC  = 2'd3
    } seq_state_t;

    // One current-limit observation taken at the end of blanking
    typedef struct packed {
        logic valid;
        logic over;
    } oc_sample_t;

endpackage

// File: rtl/ssoc_ramp.sv
module ssoc_ramp #(
    parameter int STEPS    = 64,
    parameter int STEP_CYC = 32,
    localparam int REF_W   = $clog2(STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [REF_W-1:0] ref_code,
    output logic             at_top
);
    localparam int SUB_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(STEP_CYC - 1);
    localparam logic [REF_W-1:0] TOP      = REF_W'(STEPS);

    logic [SUB_W-1:0] sub_q;
    logic [REF_W-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sub_q <= '0;
            ref_q <= '0;
        end else if (tick && ref_q != TOP) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                ref_q <= ref_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign ref_code = ref_q;
    assign at_top   = (ref_q == TOP);

    AST_REF_BOUND: assert property (@(posedge clk) disable iff (rst)
        ref_q <= TOP);  // R1
    AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && ref_q != $past(ref_q)) |-> ref_q == $past(ref_q) + 1'b1);  // R1

endmodule

// File: rtl/ssoc_skip.sv
module ssoc_skip #(
    parameter int MAX_SKIP = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic lvl_clr,
    input  logic strobe,
    input  logic fault,
    input  logic clean,
    output logic skip_now
);
    localparam int SK_W = $clog2(MAX_SKIP + 1);
    localparam logic [SK_W-1:0] MAX_L = SK_W'(MAX_SKIP);

    logic [SK_W-1:0] lvl_q, lvl_d;
    logic [SK_W-1:0] left_q, left_d;

    always_comb begin
        lvl_d  = lvl_q;
        left_d = left_q;
        if (strobe && left_q != '0)
            left_d = left_q - 1'b1;
        if (fault) begin
            lvl_d  = (lvl_q >= MAX_L) ? MAX_L : lvl_q + 1'b1;
            left_d = lvl_d;
        end else if (clean && lvl_q != '0) begin
            lvl_d = lvl_q - 1'b1;
        end
        if (lvl_clr)
            lvl_d = '0;
        if (clr) begin
            lvl_d  = '0;
            left_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            left_q <= '0;
        end else begin
            lvl_q  <= lvl_d;
            left_q <= left_d;
        end
    end

    assign skip_now = (left_q != '0);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= MAX_L && left_q <= MAX_L);  // R4
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && !$past(lvl_clr) && lvl_q < $past(lvl_q)) |-> lvl_q == $past(lvl_q) - 1'b1);  // R5

endmodule

// File: rtl/ssoc_blank.sv
module ssoc_blank
    import ssoc_pkg::*;
#(
    parameter int BLANK_CLK = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kill,
    input  logic       start,
    input  logic       oc_flag,
    output logic       win,
    output oc_sample_t samp
);
    localparam int BW = $clog2(BLANK_CLK + 1);
    localparam logic [BW-1:0] LEN = BW'(BLANK_CLK);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || kill)
            cnt_q <= '0;
        else if (start)
            cnt_q <= LEN;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign win        = (cnt_q != '0);
    assign samp.valid = (cnt_q == BW'(1));
    assign samp.over  = oc_flag;

    AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (rst)
        samp.valid |=> !samp.valid);  // R3

endmodule

// File: rtl/ssoc_seq.sv
module ssoc_seq
    import ssoc_pkg::*;
#(
    parameter int STEPS      = 64,
    parameter int STEP_CYC   = 32,
    parameter int HICCUP_CYC = 2048,
    parameter int BLANK_CLK  = 20,
    parameter int MAX_SKIP   = 7,
    localparam int REF_W     = $clog2(STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cyc_strobe,
    input  logic             oc_flag,
    output logic [REF_W-1:0] ref_code,
    output logic             pulse_allow,
    output logic             blank_win,
    output logic             st_softstart,
    output logic             st_regulate,
    output logic             st_hiccup
);
    localparam int HIC_W = (HICCUP_CYC > 1) ? $clog2(HICCUP_CYC) : 1;
    localparam logic [HIC_W-1:0] HIC_LAST = HIC_W'(HICCUP_CYC - 1);

    seq_state_t       st_q, st_d;
    oc_sample_t       samp;
    logic [HIC_W-1:0] hic_q;
    logic             pulse_q, skip_now, at_top;
    logic             active, strobe_act, fire;
    logic             hit, fault_reg, fault_ramp, clean_ramp, hic_done;

    assign active     = (st_q == SEQ_RAMP) || (st_q == SEQ_REG);
    assign strobe_act = cyc_strobe && active && en;
    assign fire       = strobe_act && !skip_now;
    assign hit        = samp.valid && pulse_q && en;
    assign fault_reg  = hit && samp.over && (st_q == SEQ_REG);
    assign fault_ramp = hit && samp.over && (st_q == SEQ_RAMP);
    assign clean_ramp = hit && !samp.over && (st_q == SEQ_RAMP);
    assign hic_done   = cyc_strobe && (st_q == SEQ_HIC) && (hic_q == HIC_LAST);

    always_comb begin
        st_d = st_q;
        case (st_q)
            SEQ_IDLE: st_d = SEQ_RAMP;
            SEQ_RAMP: if (at_top)    st_d = SEQ_REG;
            SEQ_REG:  if (fault_reg) st_d = SEQ_HIC;
            SEQ_HIC:  if (hic_done)  st_d = SEQ_RAMP;
            default:  st_d = SEQ_IDLE;
        endcase
        if (!en)
            st_d = SEQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SEQ_IDLE;
            hic_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q != SEQ_HIC)
                hic_q <= '0;
            else if (cyc_strobe)
                hic_q <= hic_q + 1'b1;
            if (!en || !active || (hit && samp.over))
                pulse_q <= 1'b0;
            else if (cyc_strobe)
                pulse_q <= !skip_now;
        end
    end

    ssoc_ramp #(.STEPS(STEPS), .STEP_CYC(STEP_CYC)) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .clr      (!en || st_q == SEQ_IDLE || st_q == SEQ_HIC || fault_reg),
        .tick     (cyc_strobe && st_q == SEQ_RAMP && en),
        .ref_code (ref_code),
        .at_top   (at_top)
    );

    ssoc_skip #(.MAX_SKIP(MAX_SKIP)) u_skip (
        .clk      (clk),
        .rst      (rst),
        .clr      (!en || st_q == SEQ_IDLE || st_q == SEQ_HIC || fault_reg),
        .lvl_clr  (st_q == SEQ_REG),
        .strobe   (strobe_act),
        .fault    (fault_ramp),
        .clean    (clean_ramp),
        .skip_now (skip_now)
    );

    ssoc_blank #(.BLANK_CLK(BLANK_CLK)) u_blank (
        .clk     (clk),
        .rst     (rst),
        .kill    (!en),
        .start   (fire),
        .oc_flag (oc_flag),
        .win     (blank_win),
        .samp    (samp)
    );

    assign pulse_allow  = pulse_q;
    assign st_softstart = (st_q == SEQ_RAMP);
    assign st_regulate  = (st_q == SEQ_REG);
    assign st_hiccup    = (st_q == SEQ_HIC);

    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
        (hit && samp.over) |=> !pulse_allow);  // R4
    AST_HIC_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_HIC) |-> (!pulse_allow && ref_code == '0));  // R6
    AST_REG_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_REG) |-> ref_code == REF_W'(STEPS));  // R2
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ref_code == '0 && !pulse_allow && !blank_win && st_q == SEQ_IDLE));  // R8

endmodule

// File: tb/ssoc_seq_tb.sv
module ssoc_seq_tb;
    localparam int STEPS = 16;
    localparam int SCYC  = 4;
    localparam int HCYC  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       cyc_strobe = 1'b0;
    logic       oc_flag = 1'b0;
    logic [4:0] ref_code;
    logic       pulse_allow, blank_win, st_softstart, st_regulate, st_hiccup;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    ssoc_seq #(.STEPS(STEPS), .STEP_CYC(SCYC), .HICCUP_CYC(HCYC),
               .BLANK_CLK(3), .MAX_SKIP(7)) u_dut (
        .clk(clk), .rst(rst), .en(en), .cyc_strobe(cyc_strobe), .oc_flag(oc_flag),
        .ref_code(ref_code), .pulse_allow(pulse_allow), .blank_win(blank_win),
        .st_softstart(st_softstart), .st_regulate(st_regulate), .st_hiccup(st_hiccup)
    );

    // {oc_flag, expected pulse_allow} per cycle of the first ramp
    localparam logic [1:0] TBL [20] = '{
        2'b11, 2'b10, 2'b11, 2'b10, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b01,
        2'b11, 2'b10, 2'b10, 2'b10, 2'b01, 2'b01, 2'b01, 2'b11, 2'b10, 2'b01
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One switching cycle of eight clocks; sampling at the falling edge
    task automatic do_cycle(input bit oc, input bit early, output bit a1, output bit b1, output bit a2);
        cyc_strobe = 1'b1;
        oc_flag    = oc | early;
        @(posedge clk);
        @(negedge clk);
        cyc_strobe = 1'b0;
        a1 = pulse_allow;
        b1 = blank_win;
        @(posedge clk);
        @(negedge clk);
        if (early) oc_flag = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        a2 = pulse_allow;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit sat_pulse(input int k);
        case (k)
            1, 3, 6, 10, 15, 21, 28, 36, 44, 52, 60, 68: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int flags();
        return {st_softstart, st_regulate, st_hiccup};
    endfunction

    initial begin
        bit a1, b1, a2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(ref_code == 0 && !pulse_allow && !blank_win, "R9", ref_code, 0);
        chk(flags() == 0, "R9 R10 flags", flags(), 0);

        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(st_softstart && ref_code == 0, "R8 enter ramp", flags(), 4);

        // Table walk: adaptive skipping during the ramp
        for (int k = 1; k <= 20; k++) begin
            do_cycle(TBL[k-1][1], 1'b0, a1, b1, a2);
            chk(a1 == TBL[k-1][0], "R4 R5 allow", a1, TBL[k-1][0]);
            chk(b1 == TBL[k-1][0], "R3 blank", b1, TBL[k-1][0]);
            chk(a2 == (TBL[k-1][0] & ~TBL[k-1][1]), "R4 end", a2, TBL[k-1][0] & ~TBL[k-1][1]);
            chk(ref_code == k / SCYC, "R1 stair", ref_code, k / SCYC);
        end

        // Disable
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(ref_code == 0 && !pulse_allow && flags() == 0, "R8 idle", ref_code, 0);
        do_cycle(1'b0, 1'b0, a1, b1, a2);
        chk(!a1 && !b1 && ref_code == 0, "R8 strobe ignored", a1, 0);

        // Sustained overcurrent from a fresh ramp
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int k = 1; k <= 68; k++) begin
            do_cycle(1'b1, 1'b0, a1, b1, a2);
            chk(a1 == sat_pulse(k), "R4 R7 skip pattern", a1, sat_pulse(k));
            chk(!a2, "R4 fault off", a2, 0);
            if (k == 64) chk(st_regulate && ref_code == STEPS, "R2 ramp end", ref_code, STEPS);
            if (k >= 65 && k <= 67) chk(st_regulate && !a1, "R7 carry skip", a1, 0);
        end
        chk(st_hiccup && ref_code == 0, "R6 enter off", flags(), 1);

        // Off-period
        for (int k = 1; k <= HCYC; k++) begin
            do_cycle(1'b1, 1'b0, a1, b1, a2);
            chk(!a1 && ref_code == 0, "R6 off no pulse", a1, 0);
            if (k < HCYC) chk(st_hiccup, "R6 off length", flags(), 1);
        end
        chk(st_softstart && ref_code == 0, "R6 restart", flags(), 4);

        // Clean ramp
        for (int k = 1; k <= STEPS * SCYC; k++) begin
            do_cycle(1'b0, 1'b0, a1, b1, a2);
            chk(a1 && a2, "R1 clean pulse", a1, 1);
            if (k % SCYC == 0) chk(ref_code == k / SCYC, "R1 stair", ref_code, k / SCYC);
        end
        chk(st_regulate && ref_code == STEPS, "R2 regulate", ref_code, STEPS);
        do_cycle(1'b0, 1'b0, a1, b1, a2);
        chk(a1 && st_regulate && ref_code == STEPS, "R2 hold", ref_code, STEPS);

        // Flag high only inside the ignored part of blanking
        do_cycle(1'b0, 1'b1, a1, b1, a2);
        chk(a1 && a2 && st_regulate, "R3 blanked", a2, 1);

        // Fault in regulation
        do_cycle(1'b1, 1'b0, a1, b1, a2);
        chk(a1 && !a2, "R6 cut", a2, 0);
        chk(st_hiccup && ref_code == 0, "R6 ref zero", ref_code, 0);
        chk(flags() == 1, "R10 one flag", flags(), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule